// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

This block is an 8-bit timer with two compare channels. It drives two waveform pins in one of four modes:

- free-running frequency generation;
- frequency generation with the period taken from compare channel 0;
- single-slope PWM with the period from the period register;
- single-slope PWM with the period from compare channel 0.

A power-of-two style prescaler sets the count rate. A direction input chooses up or down counting. Each pin has its own polarity inversion, applied after the waveform logic.

Firmware-facing logic sits outside the block. Configuration arrives as plain input levels. Status comes back as sticky flags that are cleared by one-cycle clear pulses, plus a one-cycle wrap strobe for chaining to other logic. The `run` input works as a synchronous restart. While it is low, the counter is parked at its start value, the prescaler phase is cleared, and both pins sit at the start level of the selected mode.

Top module: `wavegen_timer`

## Requirements
- R1: `presc_sel` values 0 to 7 select a divide ratio of 1, 2, 4, 8, 16, 64, 256 or 1024. After `run` rises, the counter takes its first step on the N-th active clock and then steps once every N clocks. It never changes between steps.
- R2: TOP equals `period` in modes 0 and 2, and equals `cmp0` in modes 1 and 3. Mode encoding: 0 = normal frequency, 1 = match frequency, 2 = normal PWM, 3 = match PWM.
- R3: When counting up, a step taken at TOP loads 0. When counting down (`count_down`=1), a step taken at 0 loads TOP. Every other step adds or subtracts one.
- R4: A step that wraps (at TOP going up, at 0 going down) pulses `ovf_evt` high for exactly the next clock and sets `ovf_flag`. The flag holds until an `ovf_clr` pulse arrives in a cycle with no new wrap.
- R5: A step taken while the counter equals channel k's compare value sets `match_flag[k]`. The flag holds until `match_clr[k]` is pulsed, and a new match wins over a clear in the same cycle.
- R6: In mode 0, each raw output toggles on every step that matches its own channel.
- R7: In mode 1, raw output 0 toggles on every wrapping step and raw output 1 toggles on its channel-1 match.
- R8: In PWM modes when counting up, a PWM output goes high on a wrapping step and low on a matching step. The wrap takes precedence, so a compare value of TOP or more gives a constantly high output.
- R9: In PWM modes when counting down, a PWM output goes low on a wrapping step and high on a matching step. The wrap takes precedence, so a compare value of 0 gives a constantly low output.
- R10: In mode 3, output 1 is the PWM output of channel 1 with TOP = `cmp0`. Raw output 0 is high except for a single clock right after each wrapping step, when it is low.
- R11: Each `wave[k]` equals raw output k exclusive-ORed with `inv[k]`.
- R12: After `rst_n`, the counter, the flags and the raw outputs are 0. While `run` is low, the counter loads 0 (up) or TOP (down) each clock. The raw outputs load their start levels: 1 for PWM outputs when counting up, 1 for output 0 in mode 3, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low = synchronous restart |
| count_down | input | 1 | 1 = count down, 0 = count up |
| mode | input | 2 | Waveform mode (0..3, see R2) |
| presc_sel | input | 3 | Prescaler select (see R1) |
| period | input | 8 | Period value used as TOP in modes 0 and 2 |
| cmp0 | input | 8 | Compare value of channel 0 (TOP in modes 1 and 3) |
| cmp1 | input | 8 | Compare value of channel 1 |
| inv | input | 2 | Per-pin output inversion |
| match_clr | input | 2 | Clear pulse for the match flags |
| ovf_clr | input | 1 | Clear pulse for the wrap flag |
| wave | output | 2 | Waveform pins |
| match_flag | output | 2 | Sticky per-channel match flags |
| ovf_flag | output | 1 | Sticky wrap flag |
| ovf_evt | output | 1 | One-clock wrap strobe |

## Verification
The assertions check the following on every clock:

- the counter moves only on a prescaler step;
- an up-count wrap lands on 0 and a down-count wrap reloads the TOP that was in force;
- a parked counter holds its start value;
- the sticky flags hold until cleared;
- the normal-frequency toggle, the match-frequency toggle and the match-PWM low pulse all follow their triggering events.

Only the bench scenarios can show the following:

- the exact divide ratios;
- which register supplies TOP in each mode;
- the duty cycle and the wrap-over-match precedence at the 0% and 100% corners;
- the start levels after a restart;
- the effect of inversion on the pins.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int unsigned WG_CNT_W = 8;
  localparam int unsigned WG_PRE_W = 10;
  localparam int unsigned WG_NCH   = 2;

  typedef enum logic [1:0] {
    WG_NFRQ = 2'd0,
    WG_MFRQ = 2'd1,
    WG_NPWM = 2'd2,
    WG_MPWM = 2'd3
  } wg_mode_e;

  // Low-bit mask of the prescaler phase: a step fires when all masked bits are one.
  function automatic logic [WG_PRE_W-1:0] presc_mask(input logic [2:0] sel);
    logic [WG_PRE_W-1:0] m;
    case (sel)
      3'd5:    m = WG_PRE_W'(63);
      3'd6:    m = WG_PRE_W'(255);
      3'd7:    m = WG_PRE_W'(1023);
      default: m = (WG_PRE_W'(1) << sel) - WG_PRE_W'(1);
    endcase
    return m;
  endfunction

  function automatic logic top_from_cc0(input wg_mode_e m);
    return (m == WG_MFRQ) || (m == WG_MPWM);
  endfunction

  function automatic logic start_level(input wg_mode_e m, input logic is_ch0, input logic down);
    logic lvl;
    case (m)
      WG_NPWM: lvl = !down;
      WG_MPWM: lvl = is_ch0 ? 1'b1 : !down;
      default: lvl = 1'b0;
    endcase
    return lvl;
  endfunction

  // Single-slope PWM: the wrap rule takes precedence over the compare rule.
  function automatic logic pwm_next(input logic cur, input logic down,
                                    input logic wrap, input logic hit);
    logic nxt;
    if (wrap)     nxt = !down;
    else if (hit) nxt = down;
    else          nxt = cur;
    return nxt;
  endfunction
endpackage

// File: rtl/wg_prescaler.sv
module wg_prescaler
  import wg_pkg::*;
#(
  parameter int unsigned PW = WG_PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] phase;
  logic [PW-1:0] mask;

  assign mask = PW'(presc_mask(sel));
  assign tick = run && ((phase & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= phase + PW'(1);
  end
endmodule

// File: rtl/wg_counter.sv
module wg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         down,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         upd
);
  logic hit_top;
  logic hit_zero;

  assign hit_top  = (cnt == top);
  assign hit_zero = (cnt == '0);
  assign upd      = tick && (down ? hit_zero : hit_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= down ? top : '0;
    else if (tick) begin
      if (down)      cnt <= hit_zero ? top : cnt - W'(1);
      else           cnt <= hit_top ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/wg_channel.sv
module wg_channel
  import wg_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          IS_CH0 = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         down,
  input  wg_mode_e     mode,
  input  logic         tick,
  input  logic         upd,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cc,
  input  logic         clr,
  output logic         mch,
  output logic         flag,
  output logic         wv
);
  logic wv_nxt;

  assign mch = tick && (cnt == cc);

  always_comb begin
    if (!run) begin
      wv_nxt = start_level(mode, IS_CH0, down);
    end else begin
      case (mode)
        WG_NFRQ: wv_nxt = wv ^ mch;
        WG_MFRQ: wv_nxt = IS_CH0 ? (wv ^ upd) : (wv ^ mch);
        WG_NPWM: wv_nxt = pwm_next(wv, down, upd, mch);
        default: wv_nxt = IS_CH0 ? !upd : pwm_next(wv, down, upd, mch);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv   <= 1'b0;
      flag <= 1'b0;
    end else begin
      wv   <= wv_nxt;
      flag <= (flag && !clr) || mch;
    end
  end
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
  import wg_pkg::*;
#(
  parameter int unsigned W  = WG_CNT_W,
  parameter int unsigned PW = WG_PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         count_down,
  input  logic [1:0]   mode,
  input  logic [2:0]   presc_sel,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic [1:0]   inv,
  input  logic [1:0]   match_clr,
  input  logic         ovf_clr,
  output logic [1:0]   wave,
  output logic [1:0]   match_flag,
  output logic         ovf_flag,
  output logic         ovf_evt
);
  localparam int unsigned NCH = WG_NCH;

  wg_mode_e       mode_e;
  logic           tick;
  logic           upd;
  logic [W-1:0]   cnt;
  logic [W-1:0]   top_val;
  logic [NCH-1:0] mch;
  logic [NCH-1:0] wv_raw;
  logic [W-1:0]   cc_arr [NCH];

  assign mode_e    = wg_mode_e'(mode);
  assign top_val   = top_from_cc0(mode_e) ? cmp0 : period;
  assign cc_arr[0] = cmp0;
  assign cc_arr[1] = cmp1;

  wg_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(presc_sel), .tick(tick)
  );

  wg_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .down(count_down), .tick(tick),
    .top(top_val), .cnt(cnt), .upd(upd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wg_channel #(.W(W), .IS_CH0(i == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .down(count_down), .mode(mode_e),
      .tick(tick), .upd(upd), .cnt(cnt), .cc(cc_arr[i]), .clr(match_clr[i]),
      .mch(mch[i]), .flag(match_flag[i]), .wv(wv_raw[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ovf_evt  <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag && !ovf_clr) || upd;
      ovf_evt  <= upd;
    end
  end

  assign wave = wv_raw ^ inv;
endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         count_down,
  input logic [1:0]   mode,
  input logic [1:0]   inv,
  input logic         ovf_clr,
  input logic [1:0]   match_clr,
  input logic         tick,
  input logic         upd,
  input logic [1:0]   mch,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top_val,
  input logic [1:0]   wv_raw,
  input logic [1:0]   wave,
  input logic [1:0]   match_flag,
  input logic         ovf_flag,
  input logic         ovf_evt
);
  p_step_only_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (cnt != $past(cnt))) |-> $past(tick));

  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && upd && !count_down) |=> (cnt == '0));

  p_down_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && upd && count_down) |=> (cnt == $past(top_val)));

  p_evt_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> ovf_flag);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_match0_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag[0] && !match_clr[0]) |=> match_flag[0]);

  p_match1_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag[1] && !match_clr[1]) |=> match_flag[1]);

  p_nfrq_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'd0 && mch[0]) |=> (wv_raw[0] != $past(wv_raw[0])));

  p_mfrq_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'd1 && upd) |=> (wv_raw[0] != $past(wv_raw[0])));

  p_mpwm_low_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'd3 && upd) |=> (wave[0] == inv[0]));

  p_parked_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == ($past(count_down) ? $past(top_val) : '0)));
endmodule

bind wavegen_timer wg_checker #(.W(W)) u_wg_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .count_down(count_down), .mode(mode),
  .inv(inv), .ovf_clr(ovf_clr), .match_clr(match_clr), .tick(tick), .upd(upd),
  .mch(mch), .cnt(cnt), .top_val(top_val), .wv_raw(wv_raw), .wave(wave),
  .match_flag(match_flag), .ovf_flag(ovf_flag), .ovf_evt(ovf_evt)
);

// File: tb/wavegen_timer_bench.sv
`timescale 1ns/1ps
module wavegen_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       count_down = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] presc_sel = 3'd0;
  logic [7:0] period = 8'd0, cmp0 = 8'd0, cmp1 = 8'd0;
  logic [1:0] inv = 2'b00;
  logic [1:0] match_clr = 2'b00;
  logic       ovf_clr = 1'b0;
  logic [1:0] wave, match_flag;
  logic       ovf_flag, ovf_evt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] wave;
    logic [1:0] mf;
    logic       of;
    logic       evt;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Reference state, written from the requirements.
  int         m_ph = 0;
  logic [7:0] m_cnt = 8'd0;
  logic [1:0] m_wv = 2'b00, m_mf = 2'b00;
  logic       m_of = 1'b0, m_evt = 1'b0;

  always #4 clk = ~clk;

  wavegen_timer u_wavegen_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .count_down(count_down), .mode(mode),
    .presc_sel(presc_sel), .period(period), .cmp0(cmp0), .cmp1(cmp1), .inv(inv),
    .match_clr(match_clr), .ovf_clr(ovf_clr), .wave(wave), .match_flag(match_flag),
    .ovf_flag(ovf_flag), .ovf_evt(ovf_evt)
  );

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
      3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
    endcase
  endfunction

  // Advance the reference by one clock using the inputs about to be sampled.
  task automatic model_step();
    logic [7:0] top;
    bit tk, wr;
    logic [1:0] mt;
    top = (mode == 2'd1 || mode == 2'd3) ? cmp0 : period;
    if (!run) begin m_ph = 0; tk = 0; end
    else begin m_ph++; tk = (m_ph % divisor(presc_sel)) == 0; end
    wr = tk && (count_down ? (m_cnt == 8'd0) : (m_cnt == top));
    mt[0] = tk && (m_cnt == cmp0);
    mt[1] = tk && (m_cnt == cmp1);
    for (int i = 0; i < 2; i++) begin
      if (!run) begin
        if (mode == 2'd2)      m_wv[i] = !count_down;
        else if (mode == 2'd3) m_wv[i] = (i == 0) ? 1'b1 : !count_down;
        else                   m_wv[i] = 1'b0;
      end else if (mode == 2'd0 || (mode == 2'd1 && i == 1)) begin
        if (mt[i]) m_wv[i] = !m_wv[i];
      end else if (mode == 2'd1) begin
        if (wr) m_wv[i] = !m_wv[i];
      end else if (mode == 2'd3 && i == 0) begin
        m_wv[i] = !wr;
      end else begin
        if (wr)         m_wv[i] = !count_down;
        else if (mt[i]) m_wv[i] = count_down;
      end
    end
    m_mf  = (m_mf & ~match_clr) | mt;
    m_of  = (m_of && !ovf_clr) || wr;
    m_evt = wr;
    if (!run)   m_cnt = count_down ? top : 8'd0;
    else if (tk) begin
      if (count_down) m_cnt = (m_cnt == 8'd0) ? top : m_cnt - 8'd1;
      else            m_cnt = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1;
    end
  endtask

  task automatic drive_cycle(input string tag);
    exp_t e;
    model_step();
    e.wave = m_wv ^ inv; e.mf = m_mf; e.of = m_of; e.evt = m_evt; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Scenario driver: park, run n cycles (optionally pulse clears), park again.
  task automatic play(input logic [1:0] md, input logic dn, input logic [2:0] sel,
                      input logic [7:0] per, input logic [7:0] c0, input logic [7:0] c1,
                      input logic [1:0] iv, input int n, input int clr_at, input string tag);
    run = 0; mode = md; count_down = dn; presc_sel = sel;
    period = per; cmp0 = c0; cmp1 = c1; inv = iv;
    match_clr = 2'b00; ovf_clr = 0;
    for (int k = 0; k < 2; k++) drive_cycle("R12");
    run = 1;
    for (int k = 0; k < n; k++) begin
      match_clr = (k == clr_at) ? 2'b11 : 2'b00;
      ovf_clr   = (k == clr_at);
      drive_cycle(tag);
    end
    match_clr = 2'b00; ovf_clr = 0; run = 0;
    for (int k = 0; k < 3; k++) drive_cycle("R12");
  endtask

  // Monitor: compare one scoreboard item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (wave !== e.wave || match_flag !== e.mf || ovf_flag !== e.of || ovf_evt !== e.evt) begin
          n_bad++;
          $display("FAIL %s: wave=%b mf=%b of=%b evt=%b expected wave=%b mf=%b of=%b evt=%b",
                   e.tag, wave, match_flag, ovf_flag, ovf_evt, e.wave, e.mf, e.of, e.evt);
        end
      end
    end
  end

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #21;
    n_vec++; // R12 reset state
    if (wave !== 2'b00 || match_flag !== 2'b00 || ovf_flag !== 1'b0 || ovf_evt !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 reset: wave=%b mf=%b of=%b evt=%b expected all zero",
               wave, match_flag, ovf_flag, ovf_evt);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    play(2'd0, 1'b0, 3'd0, 8'd9,   8'd3,   8'd7,   2'b00, 60,   -1, "R6");
    play(2'd0, 1'b0, 3'd0, 8'd4,   8'd2,   8'd200, 2'b00, 30,   -1, "R3");
    play(2'd0, 1'b1, 3'd2, 8'd5,   8'd0,   8'd5,   2'b00, 80,   -1, "R1");
    play(2'd1, 1'b0, 3'd0, 8'd200, 8'd4,   8'd2,   2'b00, 40,   -1, "R2");
    play(2'd1, 1'b1, 3'd1, 8'd9,   8'd6,   8'd3,   2'b00, 60,   -1, "R7");
    play(2'd2, 1'b0, 3'd0, 8'd7,   8'd2,   8'd7,   2'b00, 40,   -1, "R8");
    play(2'd2, 1'b1, 3'd0, 8'd6,   8'd3,   8'd0,   2'b00, 40,   -1, "R9");
    play(2'd3, 1'b0, 3'd1, 8'd100, 8'd5,   8'd2,   2'b00, 50,   -1, "R10");
    play(2'd3, 1'b1, 3'd0, 8'd100, 8'd4,   8'd1,   2'b00, 40,   -1, "R10");
    play(2'd2, 1'b0, 3'd0, 8'd5,   8'd3,   8'd1,   2'b11, 30,   -1, "R11");
    play(2'd3, 1'b0, 3'd0, 8'd5,   8'd3,   8'd1,   2'b01, 30,   -1, "R11");
    play(2'd0, 1'b0, 3'd0, 8'd3,   8'd1,   8'd2,   2'b00, 30,   10, "R5");
    play(2'd0, 1'b1, 3'd0, 8'd3,   8'd9,   8'd9,   2'b00, 30,   5,  "R4");
    play(2'd0, 1'b0, 3'd5, 8'd2,   8'd1,   8'd2,   2'b00, 400,  -1, "R1");
    play(2'd0, 1'b0, 3'd7, 8'd1,   8'd0,   8'd1,   2'b00, 2100, -1, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule